// File: doc/BRIEF.md
# Nibble Parity Expansion Encoder

This block takes a stream of data bytes and writes them, in protected form, into a byte-addressed one-time-programmable storage array of 8192 bits, which is 1024 byte locations. Each input nibble becomes one stored byte. The nibble is kept unchanged in the low half of that byte, and four pairwise-XOR check bits fill the high half. The output stream is therefore twice as long as the input stream. For each input byte the low nibble goes out first.

A job starts with a one-cycle `start` pulse that carries a starting array offset and a byte count N. Input bytes then arrive over a valid/ready handshake. For every accepted byte the encoder issues two writes on the array write port, at consecutive addresses. One cycle after the last write it pulses `done`. If the job would run past the end of the array, the encoder pulses `err` and writes nothing.

The controller has four states:
- **IDLE** waits for `start`. It moves to LOW when the job fits and N is nonzero, to FINISH when the job fits and N is zero, and stays in IDLE (pulsing `err`) when the job does not fit.
- **LOW** raises `in_ready`. On a handshake it issues the low-nibble write and moves to HIGH.
- **HIGH** issues the high-nibble write. It returns to LOW while bytes remain, or moves to FINISH after the last byte.
- **FINISH** lasts one cycle and then returns to IDLE. It produces the `done` pulse.

Top module: `nibx_encoder`

## Requirements
- R1: Bits 3:0 of every written byte equal the source nibble unchanged.
- R2: Written bit 4 equals d0 XOR d1, and written bit 5 equals d2 XOR d3, where d3..d0 is the source nibble.
- R3: Written bit 6 equals d0 XOR d2, and written bit 7 equals d1 XOR d3.
- R4: For each input byte, the code of bits 3:0 is written first at the current address. The code of bits 7:4 is written in the very next cycle at the current address plus one.
- R5: A job of N bytes at offset O produces exactly 2N writes, to addresses O through O+2N-1 in rising order. A job with O+2N equal to 1024 is legal.
- R6: `in_ready` is high only in LOW. It is low in the cycle after every handshake, so a new byte is accepted only after both codes of the previous byte have been issued.
- R7: A `start` with O+2N greater than 1024 produces a one-cycle `err` pulse in the next cycle. It produces no write and no `done`.
- R8: `done` is a one-cycle pulse in the cycle after the last write. A job with N = 0 gives `done` two cycles after `start`, with no write.
- R9: A `start` that arrives outside IDLE is ignored. This includes a `start` in the cycle of the last high-nibble write. A `start` in the cycle `done` is high is accepted.
- R10: After reset, `wr_en`, `done`, `err` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request pulse, taken only in IDLE |
| start_offset | input | 10 | First array byte address of the job |
| start_count | input | 10 | Number of input bytes N |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Encoder can take an input byte |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | 10 | Array byte address |
| wr_data | output | 8 | Encoded byte (check bits high, nibble low) |
| done | output | 1 | Job complete pulse |
| err | output | 1 | Out-of-range job pulse |

## Verification
Two events can fall in the same cycle: the end of one job and a `start` for the next. The bench provokes this in two ways. First, it raises `start` in the cycle of the final high-nibble write, while the controller is still in HIGH; that request must leave no writes and no second `done`. Second, it raises `start` in the very cycle `done` is high, while the controller is back in IDLE; that job must run, with its writes at its own offset.

// File: rtl/nibx_pkg.sv
package nibx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_FINISH = 2'd3
    } nibx_state_t;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/nibx_check_gen.sv
module nibx_check_gen
    import nibx_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    output logic [BYTE_W-1:0] code
);
    always_comb begin
        code[3:0] = nib;
        code[4]   = nib[0] ^ nib[1];
        code[5]   = nib[2] ^ nib[3];
        code[6]   = nib[0] ^ nib[2];
        code[7]   = nib[1] ^ nib[3];
    end
endmodule

// File: rtl/nibx_range_guard.sv
module nibx_range_guard #(
    parameter int AW    = 10,
    parameter int CW    = 10,
    parameter int DEPTH = 1024
) (
    input  logic [AW-1:0] offset,
    input  logic [CW-1:0] count,
    output logic          fits,
    output logic          empty
);
    localparam int SW = ((AW > CW + 1) ? AW : CW + 1) + 1;

    logic [SW-1:0] span_end;

    always_comb begin
        span_end = SW'(offset) + (SW'(count) << 1);
        fits     = (span_end <= SW'(DEPTH));
        empty    = (count == '0);
    end
endmodule

// File: rtl/nibx_walker.sv
module nibx_walker #(
    parameter int AW = 10,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_offset,
    input  logic [CW-1:0] load_count,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          last_byte
);
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
        end else if (load) begin
            cur_addr <= load_offset;
            remain_q <= load_count;
        end else if (step) begin
            cur_addr <= cur_addr + AW'(2);
            remain_q <= remain_q - CW'(1);
        end
    end

    assign last_byte = (remain_q == CW'(1));
endmodule

// File: rtl/nibx_encoder.sv
module nibx_encoder
    import nibx_pkg::*;
#(
    parameter  int ARRAY_BITS = 8192,
    localparam int DEPTH      = ARRAY_BITS / BYTE_W,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_offset,
    input  logic [CW-1:0]     start_count,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    localparam int LANES = BYTE_W / NIB_W;

    nibx_state_t state_q, state_d;

    logic             job_fits, job_empty;
    logic             take_job, reject_job, take_byte, emit_high;
    logic [AW-1:0]    cur_addr;
    logic             last_byte;
    logic [NIB_W-1:0] hold_hi;
    logic [NIB_W-1:0] lane_nib  [LANES];
    logic [BYTE_W-1:0] lane_code [LANES];

    nibx_range_guard #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_guard (
        .offset (start_offset),
        .count  (start_count),
        .fits   (job_fits),
        .empty  (job_empty)
    );

    assign take_job   = (state_q == ST_IDLE) && start && job_fits;
    assign reject_job = (state_q == ST_IDLE) && start && !job_fits;
    assign take_byte  = (state_q == ST_LOW) && in_valid;
    assign emit_high  = (state_q == ST_HIGH);

    nibx_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (take_job),
        .load_offset (start_offset),
        .load_count  (start_count),
        .step        (emit_high),
        .cur_addr    (cur_addr),
        .last_byte   (last_byte)
    );

    // Lane 0 encodes the live low nibble, the other lanes encode held nibbles.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_live
                assign lane_nib[g] = in_data[NIB_W-1:0];
            end else begin : g_held
                assign lane_nib[g] = hold_hi;
            end
            nibx_check_gen u_code (
                .nib  (lane_nib[g]),
                .code (lane_code[g])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_job) state_d = job_empty ? ST_FINISH : ST_LOW;
            end
            ST_LOW: begin
                if (in_valid) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                state_d = last_byte ? ST_FINISH : ST_LOW;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_ready = (state_q == ST_LOW);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            hold_hi <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            wr_en <= take_byte || emit_high;
            done  <= (state_q == ST_FINISH);
            err   <= reject_job;
            if (take_byte) begin
                wr_addr <= cur_addr;
                wr_data <= lane_code[0];
                hold_hi <= in_data[BYTE_W-1:NIB_W];
            end else if (emit_high) begin
                wr_addr <= cur_addr + AW'(1);
                wr_data <= lane_code[LANES-1];
            end
        end
    end
endmodule

// File: rtl/nibx_encoder_chk.sv
module nibx_encoder_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [7:0]    in_data,
    input logic          in_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          done,
    input logic          err
);
    assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (wr_en && wr_data[3:0] == $past(in_data[3:0])));

    assert_high_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 (wr_en && wr_data[3:0] == $past(in_data[7:4], 2)));

    assert_pair_checks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[4] == (wr_data[0] ^ wr_data[1])) &&
                  (wr_data[5] == (wr_data[2] ^ wr_data[3])));

    assert_cross_checks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[6] == (wr_data[0] ^ wr_data[2])) &&
                  (wr_data[7] == (wr_data[1] ^ wr_data[3])));

    assert_next_address_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 (wr_en && (wr_addr - $past(wr_addr)) == AW'(1)));

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_en && !done) ##1 (!err && !wr_en));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en ##1 !done);
endmodule

bind nibx_encoder nibx_encoder_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .err      (err)
);

// File: tb/nibx_encoder_test.sv
`timescale 1ns/1ps
module nibx_encoder_test;
    localparam int AW = 10;
    localparam int NV = 7;
    // {input byte, expected low code, expected high code}
    localparam logic [23:0] VEC [NV] = '{
        24'h21_51_92, 24'h5A_3A_35, 24'hF0_00_0F, 24'h84_64_A8,
        24'h96_F6_F9, 24'hE7_A7_5E, 24'h3C_CC_C3
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_offset = '0;
    logic [AW-1:0] start_count = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, wr_en, done, err;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0, errors = 0;
    int cyc = 0, nwr = 0, ndone = 0, nerr = 0, last_wr_cyc = 0, done_cyc = 0;
    logic [AW-1:0] log_addr [64];
    logic [7:0]    log_data [64];

    always #2 clk = ~clk;

    nibx_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
        .start_count(start_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) begin
            if (nwr < 64) begin
                log_addr[nwr] <= wr_addr;
                log_data[nwr] <= wr_data;
            end
            nwr <= nwr + 1;
            last_wr_cyc <= cyc;
        end
        if (done) begin
            ndone <= ndone + 1;
            done_cyc <= cyc;
        end
        if (err) nerr <= nerr + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        nwr = 0; ndone = 0; nerr = 0;
    endtask

    task automatic kick(input int off, input int cnt);
        start = 1'b1;
        start_offset = AW'(off);
        start_count = AW'(cnt);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R6 ready low in high-nibble cycle", int'(in_ready), 0);
        in_valid = 1'b0;
        in_data = 8'h00;
    endtask

    task automatic check_job(input int off, input int first, input int n, input string tag);
        chk(nwr == 2 * n, {tag, " R5 write count"}, nwr, 2 * n);
        for (int i = 0; i < n && 2 * i + 1 < 64; i++) begin
            chk(log_addr[2*i] == AW'(off + 2*i), {tag, " R4 low address"},
                int'(log_addr[2*i]), off + 2*i);
            chk(log_addr[2*i+1] == AW'(off + 2*i + 1), {tag, " R4 high address"},
                int'(log_addr[2*i+1]), off + 2*i + 1);
            chk(log_data[2*i] == VEC[first+i][15:8], {tag, " R1 R2 R3 low code"},
                int'(log_data[2*i]), int'(VEC[first+i][15:8]));
            chk(log_data[2*i+1] == VEC[first+i][7:0], {tag, " R1 R2 R3 high code"},
                int'(log_data[2*i+1]), int'(VEC[first+i][7:0]));
        end
        chk(ndone == 1, {tag, " R8 one done"}, ndone, 1);
        chk(done_cyc == last_wr_cyc + 1, {tag, " R8 done after last write"},
            done_cyc - last_wr_cyc, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !done && !err && !in_ready, "R10 reset outputs",
            {wr_en, done, err, in_ready}, 0);

        // Table walk: all vectors in one job, with gaps between bytes.
        clear_log();
        kick(100, NV);
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][23:16]);
            if (i % 2 == 1) repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check_job(100, 0, NV, "table");

        // Exact upper boundary is legal (R5).
        clear_log();
        kick(1020, 2);
        send(VEC[2][23:16]);
        send(VEC[3][23:16]);
        repeat (4) @(negedge clk);
        check_job(1020, 2, 2, "boundary");
        chk(nerr == 0, "R5 no err at exact end", nerr, 0);

        // One location too far: err, nothing written (R7).
        clear_log();
        kick(1020, 3);
        repeat (4) @(negedge clk);
        chk(nerr == 1, "R7 single err pulse", nerr, 1);
        chk(nwr == 0, "R7 no writes", nwr, 0);
        chk(ndone == 0, "R7 no done", ndone, 0);
        chk(in_ready == 1'b0, "R7 stays idle", int'(in_ready), 0);

        // Zero-length job (R8).
        clear_log();
        kick(5, 0);
        @(negedge clk);
        chk(done == 1'b1, "R8 zero job done timing", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(ndone == 1 && nwr == 0, "R8 zero job no writes", nwr, 0);

        // Start while busy and in the last high-write cycle is ignored (R9).
        clear_log();
        kick(0, 2);
        kick(500, 1);
        send(VEC[4][23:16]);
        start = 1'b1;
        start_offset = AW'(600);
        start_count = AW'(1);
        send(VEC[5][23:16]);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check_job(0, 4, 2, "busy-start");
        chk(in_ready == 1'b0, "R9 ignored start left idle", int'(in_ready), 0);

        // Start on the done cycle is taken (R9).
        clear_log();
        kick(300, 1);
        send(VEC[6][23:16]);
        while (!done) @(negedge clk);
        kick(400, 1);
        clear_log();
        send(VEC[0][23:16]);
        repeat (4) @(negedge clk);
        check_job(400, 0, 1, "done-start R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule